// File: doc/BRIEF.md
# Segmented Address Translator

This block turns a 16-bit logical address into a 20-bit physical address through a four-entry segment table. The two most significant address bits pick a table entry and the remaining 14 bits are an offset into that segment. Each entry stores a physical base, a limit and independent read and write permission bits. A request whose offset lies above the entry's limit, or whose access type is not permitted, is refused with a fault flag. A legal request returns the base plus the offset.

The table has a single write port. A write takes effect only while the privilege input is high, so only context-switch software running in privileged mode can load a new process's segments. A combinational read-back port shows any entry so that software can save the outgoing context. Each result is registered and appears one cycle after its request.

Top module: `seg_xlate_top`

## Requirements
- R1: The segment index is bits [15:14] of `req_addr_i`, and the offset is bits [13:0].
- R2: Each of the four entries holds its own 20-bit base, 14-bit limit, read-enable bit and write-enable bit. A write to one entry leaves the other entries unchanged.
- R3: An offset strictly greater than the selected entry's limit raises `rsp_lim_fault_o` and keeps `rsp_valid_o` low. An offset equal to the limit is within bounds.
- R4: A legal request raises `rsp_valid_o` with `rsp_addr_o` equal to (base + offset) modulo 2^20.
- R5: A read (`req_write_i`=0) to an entry whose read-enable bit is 0 raises `rsp_perm_fault_o`. A write (`req_write_i`=1) to an entry whose write-enable bit is 0 also raises `rsp_perm_fault_o`. A read-only code segment therefore faults on writes.
- R6: A request that breaks both the limit and the permission raises both fault outputs in the same cycle.
- R7: A table write with `priv_i`=0 is refused, and the addressed entry keeps its previous contents.
- R8: Every request cycle produces exactly one response in the following cycle: either `rsp_valid_o`, or one or both fault flags. Cycles without a request produce neither. `rsp_addr_o` is zero whenever `rsp_valid_o` is low.
- R9: After reset, every entry has base 0, limit 0 and no permissions, and all outputs are low. Any access before configuration therefore raises a permission fault.
- R10: The read-back port shows entry `rb_idx_i` combinationally. A table write becomes visible from the next cycle on. A request issued in the same cycle as a write uses the old contents.
- R11: Translation and checking apply identically whatever the value of `priv_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Translation request this cycle |
| req_addr_i | input | 16 | Logical address |
| req_write_i | input | 1 | Access type: 1 write, 0 read |
| priv_i | input | 1 | Privileged mode; enables table writes |
| tbl_we_i | input | 1 | Table write strobe |
| tbl_idx_i | input | 2 | Entry to write |
| tbl_base_i | input | 20 | Base value to write |
| tbl_limit_i | input | 14 | Limit value to write |
| tbl_rd_i | input | 1 | Read-enable value to write |
| tbl_wr_i | input | 1 | Write-enable value to write |
| rb_idx_i | input | 2 | Entry to read back |
| rb_base_o | output | 20 | Read-back base |
| rb_limit_o | output | 14 | Read-back limit |
| rb_rd_o | output | 1 | Read-back read-enable |
| rb_wr_o | output | 1 | Read-back write-enable |
| rsp_valid_o | output | 1 | Legal translation result |
| rsp_addr_o | output | 20 | Physical address, zero unless valid |
| rsp_lim_fault_o | output | 1 | Offset exceeded limit |
| rsp_perm_fault_o | output | 1 | Access type not permitted |

## Verification
The bench targets the limit boundary, where offset equal to the limit must pass and limit plus one must fault. A design with an off-by-one compare would either reject the last legal byte or accept one illegal byte. It also tests a base near the top of the physical space, where an adder that is too narrow or that saturates would produce the wrong wrapped address. A request in the same cycle as a write to its own entry shows whether the write bypasses into the lookup. A user-mode write followed by a read-back exposes a missing privilege gate. Random traffic covers requests that break both the limit and the permission, to catch a design that reports only one of the two faults.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int unsigned LA_W_DEF  = 16;
  localparam int unsigned SEG_W_DEF = 2;
  localparam int unsigned PA_W_DEF  = 20;

  typedef enum logic {
    ACC_READ  = 1'b0,
    ACC_WRITE = 1'b1
  } acc_e;

  typedef struct packed {
    logic lim;
    logic perm;
  } fault_t;
endpackage

// File: rtl/seg_table.sv
module seg_table #(
  parameter int unsigned SEG_W = 2,
  parameter int unsigned OFF_W = 14,
  parameter int unsigned PA_W  = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             priv_i,
  input  logic             we_i,
  input  logic [SEG_W-1:0] we_idx_i,
  input  logic [PA_W-1:0]  we_base_i,
  input  logic [OFF_W-1:0] we_limit_i,
  input  logic             we_rd_i,
  input  logic             we_wr_i,
  input  logic [SEG_W-1:0] lk_idx_i,
  output logic [PA_W-1:0]  lk_base_o,
  output logic [OFF_W-1:0] lk_limit_o,
  output logic             lk_rd_o,
  output logic             lk_wr_o,
  input  logic [SEG_W-1:0] rb_idx_i,
  output logic [PA_W-1:0]  rb_base_o,
  output logic [OFF_W-1:0] rb_limit_o,
  output logic             rb_rd_o,
  output logic             rb_wr_o
);
  localparam int unsigned NSEG = 1 << SEG_W;

  logic [PA_W-1:0]  base_q  [NSEG];
  logic [OFF_W-1:0] limit_q [NSEG];
  logic [NSEG-1:0]  rd_q;
  logic [NSEG-1:0]  wr_q;

  // privilege gates every table update
  logic upd_en;
  assign upd_en = we_i & priv_i;

  for (genvar g = 0; g < NSEG; g++) begin : g_ent
    logic hit;
    assign hit = upd_en && (we_idx_i == SEG_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[g]  <= '0;
        limit_q[g] <= '0;
        rd_q[g]    <= 1'b0;
        wr_q[g]    <= 1'b0;
      end else if (hit) begin
        base_q[g]  <= we_base_i;
        limit_q[g] <= we_limit_i;
        rd_q[g]    <= we_rd_i;
        wr_q[g]    <= we_wr_i;
      end
    end
  end

  assign lk_base_o  = base_q[lk_idx_i];
  assign lk_limit_o = limit_q[lk_idx_i];
  assign lk_rd_o    = rd_q[lk_idx_i];
  assign lk_wr_o    = wr_q[lk_idx_i];

  assign rb_base_o  = base_q[rb_idx_i];
  assign rb_limit_o = limit_q[rb_idx_i];
  assign rb_rd_o    = rd_q[rb_idx_i];
  assign rb_wr_o    = wr_q[rb_idx_i];
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int unsigned OFF_W = 14,
  parameter int unsigned PA_W  = 20
) (
  input  logic [PA_W-1:0]  base_i,
  input  logic [OFF_W-1:0] limit_i,
  input  logic             rd_ok_i,
  input  logic             wr_ok_i,
  input  logic [OFF_W-1:0] off_i,
  input  acc_e             acc_i,
  output logic [PA_W-1:0]  phys_o,
  output fault_t           fault_o
);
  localparam int unsigned EXT_W = PA_W - OFF_W;

  logic [PA_W-1:0] off_ext;
  assign off_ext = {{EXT_W{1'b0}}, off_i};

  // wraps modulo 2^PA_W
  assign phys_o = base_i + off_ext;

  always_comb begin
    fault_o.lim  = off_i > limit_i;
    fault_o.perm = (acc_i == ACC_WRITE) ? ~wr_ok_i : ~rd_ok_i;
  end
endmodule

// File: rtl/seg_rsp_reg.sv
module seg_rsp_reg
  import seg_xlate_pkg::*;
#(
  parameter int unsigned PA_W = 20
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic [PA_W-1:0] phys_i,
  input  fault_t          fault_i,
  output logic            valid_o,
  output logic [PA_W-1:0] addr_o,
  output logic            lim_fault_o,
  output logic            perm_fault_o
);
  logic ok;
  assign ok = req_valid_i & ~fault_i.lim & ~fault_i.perm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o      <= 1'b0;
      addr_o       <= '0;
      lim_fault_o  <= 1'b0;
      perm_fault_o <= 1'b0;
    end else begin
      valid_o      <= ok;
      addr_o       <= ok ? phys_i : '0;
      lim_fault_o  <= req_valid_i & fault_i.lim;
      perm_fault_o <= req_valid_i & fault_i.perm;
    end
  end
endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
  import seg_xlate_pkg::*;
#(
  parameter int unsigned LA_W  = LA_W_DEF,
  parameter int unsigned SEG_W = SEG_W_DEF,
  parameter int unsigned PA_W  = PA_W_DEF,
  localparam int unsigned OFF_W = LA_W - SEG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [LA_W-1:0]  req_addr_i,
  input  logic             req_write_i,
  input  logic             priv_i,
  input  logic             tbl_we_i,
  input  logic [SEG_W-1:0] tbl_idx_i,
  input  logic [PA_W-1:0]  tbl_base_i,
  input  logic [OFF_W-1:0] tbl_limit_i,
  input  logic             tbl_rd_i,
  input  logic             tbl_wr_i,
  input  logic [SEG_W-1:0] rb_idx_i,
  output logic [PA_W-1:0]  rb_base_o,
  output logic [OFF_W-1:0] rb_limit_o,
  output logic             rb_rd_o,
  output logic             rb_wr_o,
  output logic             rsp_valid_o,
  output logic [PA_W-1:0]  rsp_addr_o,
  output logic             rsp_lim_fault_o,
  output logic             rsp_perm_fault_o
);
  logic [SEG_W-1:0] seg_idx;
  logic [OFF_W-1:0] seg_off;
  assign seg_idx = req_addr_i[LA_W-1 -: SEG_W];
  assign seg_off = req_addr_i[OFF_W-1:0];

  logic [PA_W-1:0]  lk_base;
  logic [OFF_W-1:0] lk_limit;
  logic             lk_rd;
  logic             lk_wr;
  logic [PA_W-1:0]  phys;
  fault_t           fault;
  acc_e             acc;

  assign acc = req_write_i ? ACC_WRITE : ACC_READ;

  seg_table #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .priv_i     (priv_i),
    .we_i       (tbl_we_i),
    .we_idx_i   (tbl_idx_i),
    .we_base_i  (tbl_base_i),
    .we_limit_i (tbl_limit_i),
    .we_rd_i    (tbl_rd_i),
    .we_wr_i    (tbl_wr_i),
    .lk_idx_i   (seg_idx),
    .lk_base_o  (lk_base),
    .lk_limit_o (lk_limit),
    .lk_rd_o    (lk_rd),
    .lk_wr_o    (lk_wr),
    .rb_idx_i   (rb_idx_i),
    .rb_base_o  (rb_base_o),
    .rb_limit_o (rb_limit_o),
    .rb_rd_o    (rb_rd_o),
    .rb_wr_o    (rb_wr_o)
  );

  seg_check #(.OFF_W(OFF_W), .PA_W(PA_W)) u_check (
    .base_i  (lk_base),
    .limit_i (lk_limit),
    .rd_ok_i (lk_rd),
    .wr_ok_i (lk_wr),
    .off_i   (seg_off),
    .acc_i   (acc),
    .phys_o  (phys),
    .fault_o (fault)
  );

  seg_rsp_reg #(.PA_W(PA_W)) u_rsp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .phys_i       (phys),
    .fault_i      (fault),
    .valid_o      (rsp_valid_o),
    .addr_o       (rsp_addr_o),
    .lim_fault_o  (rsp_lim_fault_o),
    .perm_fault_o (rsp_perm_fault_o)
  );
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int unsigned LA_W  = 16,
  parameter int unsigned SEG_W = 2,
  parameter int unsigned PA_W  = 20,
  localparam int unsigned OFF_W = LA_W - SEG_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             priv_i,
  input logic             tbl_we_i,
  input logic [SEG_W-1:0] rb_idx_i,
  input logic [PA_W-1:0]  rb_base_o,
  input logic [OFF_W-1:0] rb_limit_o,
  input logic             rb_rd_o,
  input logic             rb_wr_o,
  input logic             rsp_valid_o,
  input logic [PA_W-1:0]  rsp_addr_o,
  input logic             rsp_lim_fault_o,
  input logic             rsp_perm_fault_o
);
  logic any_rsp;
  assign any_rsp = rsp_valid_o | rsp_lim_fault_o | rsp_perm_fault_o;

  // R8
  result_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rsp_valid_o && (rsp_lim_fault_o || rsp_perm_fault_o)));

  // R8
  rsp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> any_rsp);

  // R8
  no_spurious_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_rsp |-> $past(req_valid_i));

  // R8
  addr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (rsp_addr_o == '0));

  // R7
  tbl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rb_idx_i == $past(rb_idx_i) && !$past(tbl_we_i && priv_i))
      |-> ($stable(rb_base_o) && $stable(rb_limit_o) && $stable(rb_rd_o) && $stable(rb_wr_o)));
endmodule

bind seg_xlate_top seg_xlate_chk #(.LA_W(LA_W), .SEG_W(SEG_W), .PA_W(PA_W)) chk_i (.*);

// File: tb/seg_xlate_top_tb_top.sv
module seg_xlate_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [15:0] req_addr_i = '0;
  logic        req_write_i = 1'b0;
  logic        priv_i = 1'b0;
  logic        tbl_we_i = 1'b0;
  logic [1:0]  tbl_idx_i = '0;
  logic [19:0] tbl_base_i = '0;
  logic [13:0] tbl_limit_i = '0;
  logic        tbl_rd_i = 1'b0;
  logic        tbl_wr_i = 1'b0;
  logic [1:0]  rb_idx_i = '0;
  logic [19:0] rb_base_o;
  logic [13:0] rb_limit_o;
  logic        rb_rd_o;
  logic        rb_wr_o;
  logic        rsp_valid_o;
  logic [19:0] rsp_addr_o;
  logic        rsp_lim_fault_o;
  logic        rsp_perm_fault_o;

  int checks = 0;
  int failures = 0;

  always #10 clk_i = ~clk_i;

  seg_xlate_top dut_i (.*);

  // bench model of the table
  logic [19:0] m_base  [4];
  logic [13:0] m_limit [4];
  logic        m_rd    [4];
  logic        m_wr    [4];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [22:0] expect_rsp(input logic [15:0] a, input logic w);
    logic [1:0]  s;
    logic [13:0] o;
    logic        lf, pf;
    logic [19:0] p;
    s  = a[15:14];
    o  = a[13:0];
    lf = o > m_limit[s];
    pf = w ? !m_wr[s] : !m_rd[s];
    p  = m_base[s] + {6'd0, o};
    if (lf || pf) return {1'b0, lf, pf, 20'd0};
    return {1'b1, 1'b0, 1'b0, p};
  endfunction

  // caller is at a negedge; returns at the next negedge
  task automatic tbl_write(input logic [1:0] i, input logic [19:0] b, input logic [13:0] l,
                           input logic r, input logic w, input logic pv);
    tbl_we_i = 1'b1; tbl_idx_i = i; tbl_base_i = b; tbl_limit_i = l;
    tbl_rd_i = r; tbl_wr_i = w; priv_i = pv;
    @(negedge clk_i);
    tbl_we_i = 1'b0;
    if (pv) begin
      m_base[i] = b; m_limit[i] = l; m_rd[i] = r; m_wr[i] = w;
    end
  endtask

  task automatic xlate(input logic [15:0] a, input logic w, input logic pv, input string tag);
    logic [22:0] e;
    e = expect_rsp(a, w);
    req_valid_i = 1'b1; req_addr_i = a; req_write_i = w; priv_i = pv;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk({rsp_valid_o, rsp_lim_fault_o, rsp_perm_fault_o, rsp_addr_o} == e, tag,
        {rsp_valid_o, rsp_lim_fault_o, rsp_perm_fault_o, rsp_addr_o}, e);
  endtask

  task automatic readback(input logic [1:0] i, input string tag);
    logic [35:0] e;
    rb_idx_i = i;
    #1;
    e = {m_base[i], m_limit[i], m_rd[i], m_wr[i]};
    chk({rb_base_o, rb_limit_o, rb_rd_o, rb_wr_o} == e, tag,
        {rb_base_o, rb_limit_o, rb_rd_o, rb_wr_o}, e);
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4; i++) begin
      m_base[i] = '0; m_limit[i] = '0; m_rd[i] = 1'b0; m_wr[i] = 1'b0;
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R9 reset state
    chk({rsp_valid_o, rsp_lim_fault_o, rsp_perm_fault_o, rsp_addr_o} == 23'd0, "R9 outputs",
        {rsp_valid_o, rsp_lim_fault_o, rsp_perm_fault_o, rsp_addr_o}, 0);
    for (int i = 0; i < 4; i++) readback(2'(i), "R9 readback");
    xlate(16'h0000, 1'b0, 1'b0, "R9 unconfigured perm");
    xlate(16'h4001, 1'b1, 1'b0, "R6 both faults unconfigured");

    // R7 user-mode write refused
    tbl_write(2'd1, 20'hABCDE, 14'h0100, 1'b1, 1'b1, 1'b0);
    readback(2'd1, "R7 refused write");
    xlate(16'h4000, 1'b0, 1'b0, "R7 still faults");

    // configure: seg0 read-only code, seg1 rw, seg2 rw near top, seg3 write-only
    tbl_write(2'd0, 20'h10000, 14'h0FFF, 1'b1, 1'b0, 1'b1);
    tbl_write(2'd1, 20'h20000, 14'h3FFF, 1'b1, 1'b1, 1'b1);
    tbl_write(2'd2, 20'hFF000, 14'h2000, 1'b1, 1'b1, 1'b1);
    tbl_write(2'd3, 20'h00400, 14'h0000, 1'b0, 1'b1, 1'b1);
    readback(2'd2, "R2 R10 readback seg2");
    readback(2'd0, "R2 readback seg0");

    xlate(16'h0FFF, 1'b0, 1'b0, "R3 R4 offset at limit");
    xlate(16'h1000, 1'b0, 1'b0, "R3 offset over limit");
    xlate(16'h0005, 1'b1, 1'b0, "R5 write to read-only");
    xlate(16'h1000, 1'b1, 1'b0, "R6 both faults");
    xlate(16'h4123, 1'b0, 1'b0, "R1 R11 seg1 user");
    xlate(16'h4123, 1'b0, 1'b1, "R11 seg1 priv");
    xlate(16'h9800, 1'b1, 1'b0, "R4 wrap");
    xlate(16'hC000, 1'b0, 1'b0, "R5 read of write-only");
    xlate(16'hC000, 1'b1, 1'b0, "R5 write-only ok");

    // R8 idle cycle produces nothing
    @(negedge clk_i);
    chk({rsp_valid_o, rsp_lim_fault_o, rsp_perm_fault_o} == 3'b000, "R8 idle",
        {rsp_valid_o, rsp_lim_fault_o, rsp_perm_fault_o}, 0);

    // R10 write and request to the same entry in one cycle: old contents used
    begin
      logic [22:0] e;
      e = expect_rsp(16'h4010, 1'b0);
      req_valid_i = 1'b1; req_addr_i = 16'h4010; req_write_i = 1'b0;
      tbl_write(2'd1, 20'h30000, 14'h3FFF, 1'b1, 1'b1, 1'b1);
      req_valid_i = 1'b0;
      chk({rsp_valid_o, rsp_lim_fault_o, rsp_perm_fault_o, rsp_addr_o} == e, "R10 old contents",
          {rsp_valid_o, rsp_lim_fault_o, rsp_perm_fault_o, rsp_addr_o}, e);
    end
    xlate(16'h4010, 1'b0, 1'b0, "R10 new contents");

    // random mix
    for (int n = 0; n < 600; n++) begin
      int unsigned op;
      op = $urandom_range(0, 9);
      if (op < 3) begin
        tbl_write(2'($urandom_range(0, 3)), 20'($urandom()), 14'($urandom()),
                  1'($urandom()), 1'($urandom()), 1'($urandom_range(0, 3) != 0));
        readback(2'($urandom_range(0, 3)), "R2 R7 random readback");
      end else if (op < 9) begin
        logic [13:0] o;
        logic [1:0]  s;
        s = 2'($urandom_range(0, 3));
        o = ($urandom_range(0, 1) != 0) ? m_limit[s] + 14'($urandom_range(0, 2)) : 14'($urandom());
        xlate({s, o}, 1'($urandom()), 1'($urandom()), "R3 R4 R5 R6 random");
      end else begin
        @(negedge clk_i);
        chk({rsp_valid_o, rsp_lim_fault_o, rsp_perm_fault_o} == 3'b000, "R8 random idle",
            {rsp_valid_o, rsp_lim_fault_o, rsp_perm_fault_o}, 0);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule